// File: doc/BRIEF.md
# Ones-Complement Rotating Block Checksum Engine

This engine walks a block of 16-bit words in memory and folds them into a 16-bit checksum. Each word is added to a running sum with ones-complement end-around carry, and the sum is then rotated left by one bit. The caller supplies a first address, a word count and an initial partial sum, which is zero for a fresh computation. It then pulses `start`. The engine reads the words one at a time through a request/valid memory port. When it has finished it pulses `done` and presents the checksum. An all-ones result is reported as zero.

Before each word the engine samples a suspend request. If the request is present and enabled, the engine stops and pulses `suspended`. It then presents its current address, remaining count and raw partial sum. Starting again with those three values as inputs produces the same final checksum as a run that was never suspended.

Top module: `ocsum_engine`

## Requirements
- R1: After reset `busy`, `done`, `suspended` and `mem_req` are 0. A `start` sampled while idle makes `busy` 1 from the next cycle. `busy` falls in the cycle that `done` or `suspended` is 1.
- R2: For each word W, the sum S becomes T rotated left by one bit (bit 15 moves to bit 0). Here T = S+W taken modulo 2^16, plus 1 when that addition carries out of bit 15.
- R3: The k-th read (k from 0) uses address `start_addr`+k. After each accepted word the address register rises by 1 and the count register falls by 1.
- R4: If the final sum is 16'hFFFF, `sum_o` reads 16'h0000 while `done` is 1.
- R5: A start with count 0 reads no memory. It raises `done` after the second rising edge, counting the edge that samples `start` as the first. `sum_o` then equals the initial sum, with R4 applied.
- R6: When `suspend_req` and `suspend_en` are both 1 at a word boundary with words left, `suspended` pulses for one cycle and no read is issued. `addr_o`, `cnt_o` and `sum_o` then hold the next address, the remaining count and the raw partial sum. Restarting with these values gives the uninterrupted checksum.
- R7: `suspend_req` with `suspend_en` at 0 has no effect: the run completes with the normal result and timing.
- R8: A `start` pulse while `busy` is 1 is ignored, and the run in progress is unchanged.
- R9: A word boundary lasts one cycle. `mem_req` is then held until the cycle in which `mem_valid` is 1. With a memory that answers L cycles after the request rises, each word costs L+2 cycles. For N words, `done` is 1 after edge N*(L+2)+1, counting the edge that samples `start` as edge 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (ignored while busy) |
| start_addr | input | AW | First word address |
| start_count | input | CW | Number of words |
| start_sum | input | 16 | Initial partial sum |
| suspend_req | input | 1 | Request to stop at the next word boundary |
| suspend_en | input | 1 | Enables honouring `suspend_req` |
| mem_req | output | 1 | Read request, held until `mem_valid` |
| mem_addr | output | AW | Read address |
| mem_rdata | input | 16 | Read data, sampled with `mem_valid` |
| mem_valid | input | 1 | Read data valid |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| suspended | output | 1 | One-cycle suspend pulse |
| sum_o | output | 16 | Checksum on `done`, partial sum on `suspended` |
| addr_o | output | AW | Current address register |
| cnt_o | output | CW | Remaining word count |

## Verification
A boundary cycle follows the edge that samples `start`, so `busy` is due one edge after `start`. A word finishes on the edge that captures `mem_valid`, and `done` or `suspended` appears one edge after the final boundary. The bench's behavioural model advances on the same edges, and it drives memory latency from a negedge process so that the cycle of `mem_valid` is known. All outputs are compared at each falling edge, away from the updating edge. Explicit edge counts taken between `start` and `done` confirm the N*(L+2)+1 figure for several latencies.

// File: rtl/ocsum_engine.sv
module ocsum_engine #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] start_count,
  input  logic [15:0]   start_sum,
  input  logic          suspend_req,
  input  logic          suspend_en,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic [15:0]   mem_rdata,
  input  logic          mem_valid,
  output logic          busy,
  output logic          done,
  output logic          suspended,
  output logic [15:0]   sum_o,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o
);
  typedef enum logic [1:0] {S_IDLE, S_BND, S_WAIT} st_t;

  st_t           st;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic [15:0]   sum_q;
  logic [16:0]   add_w;
  logic [15:0]   wrap_w;

  assign add_w  = {1'b0, sum_q} + {1'b0, mem_rdata};
  assign wrap_w = add_w[15:0] + {15'b0, add_w[16]};

  assign mem_req  = (st == S_WAIT);
  assign mem_addr = addr_q;
  assign busy     = (st != S_IDLE);
  assign sum_o    = sum_q;
  assign addr_o   = addr_q;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      addr_q    <= '0;
      cnt_q     <= '0;
      sum_q     <= '0;
      done      <= 1'b0;
      suspended <= 1'b0;
    end else begin
      done      <= 1'b0;
      suspended <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          addr_q <= start_addr;
          cnt_q  <= start_count;
          sum_q  <= start_sum;
          st     <= S_BND;
        end
        S_BND: begin
          if (cnt_q == '0) begin
            if (sum_q == 16'hFFFF) sum_q <= '0;
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (suspend_req && suspend_en) begin
            suspended <= 1'b1;
            st        <= S_IDLE;
          end else begin
            st <= S_WAIT;
          end
        end
        S_WAIT: if (mem_valid) begin
          sum_q  <= {wrap_w[14:0], wrap_w[15]};
          addr_q <= addr_q + 1'b1;
          cnt_q  <= cnt_q - 1'b1;
          st     <= S_BND;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ocsum_engine_chk.sv
module ocsum_engine_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          suspend_req,
  input logic          suspend_en,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_valid,
  input logic          busy,
  input logic          done,
  input logic          suspended,
  input logic [15:0]   sum_o,
  input logic [AW-1:0] addr_o,
  input logic [CW-1:0] cnt_o
);
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy); // R1
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (done || suspended) |-> !busy); // R1
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid) |=> (addr_o == $past(mem_addr) + 1'b1)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid) |=> (cnt_o == $past(cnt_o) - 1'b1)); // R3
  AST_NO_MINUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sum_o != 16'hFFFF)); // R4
  AST_SUSPEND_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> $past(suspend_req && suspend_en)); // R7
  AST_SUSPEND_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !mem_req); // R6
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy); // R9
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, suspended})); // R1
endmodule

bind ocsum_engine ocsum_engine_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .suspend_req(suspend_req),
  .suspend_en(suspend_en), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_valid(mem_valid), .busy(busy), .done(done), .suspended(suspended),
  .sum_o(sum_o), .addr_o(addr_o), .cnt_o(cnt_o)
);

// File: tb/sim_ocsum_engine.sv
module sim_ocsum_engine;
  localparam int AW = 16;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] start_count = '0;
  logic [15:0] start_sum = '0;
  logic suspend_req = 1'b0, suspend_en = 1'b0;
  logic mem_req, mem_valid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic busy, done, suspended;
  logic [15:0] sum_o;
  logic [AW-1:0] addr_o;
  logic [CW-1:0] cnt_o;

  int tests = 0, fails = 0;
  int lat = 0, wcnt = 0;
  logic [15:0] mem [0:255];

  always #2 clk = ~clk;

  ocsum_engine #(.AW(AW), .CW(CW)) u0 (.*);

  function automatic int fold(int s, int w);
    int t;
    t = s + w;
    if (t > 65535) t = t - 65535;
    return ((t * 2) % 65536) + (t / 32768);
  endfunction

  function automatic int ref_sum(int base, int n, int init);
    int s = init;
    for (int i = 0; i < n; i++) s = fold(s, mem[(base + i) % 256]);
    return (s == 65535) ? 0 : s;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory with programmable latency, driven away from the rising edge
  always @(negedge clk) begin
    if (mem_req) begin
      if (wcnt == lat) begin
        mem_valid <= 1'b1;
        mem_rdata <= mem[mem_addr[7:0]];
        wcnt <= wcnt + 1;
      end else begin
        mem_valid <= 1'b0;
        wcnt <= wcnt + 1;
      end
    end else begin
      mem_valid <= 1'b0;
      wcnt <= 0;
    end
  end

  // cycle-level reference model
  int m_ph = 0, m_addr = 0, m_cnt = 0, m_sum = 0;
  bit m_done = 0, m_susp = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_addr = 0; m_cnt = 0; m_sum = 0; m_done = 0; m_susp = 0;
    end else begin
      m_done = 0; m_susp = 0;
      if (m_ph == 0) begin
        if (start) begin
          m_addr = start_addr; m_cnt = start_count; m_sum = start_sum; m_ph = 1;
        end
      end else if (m_ph == 1) begin
        if (m_cnt == 0) begin
          if (m_sum == 65535) m_sum = 0;
          m_done = 1; m_ph = 0;
        end else if (suspend_req && suspend_en) begin
          m_susp = 1; m_ph = 0;
        end else m_ph = 2;
      end else if (mem_valid) begin
        m_sum = fold(m_sum, mem_rdata);
        m_addr = (m_addr + 1) % 65536;
        m_cnt = m_cnt - 1;
        m_ph = 1;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    check("R1 busy", busy, m_ph != 0);
    check("R9 mem_req", mem_req, m_ph == 2);
    if (m_ph == 2) check("R3 mem_addr", mem_addr, m_addr);
    check("R5 done", done, m_done);
    check("R6 suspended", suspended, m_susp);
    if (m_done) check("R2 sum at done", sum_o, m_sum);
    if (m_susp) begin
      check("R6 partial sum", sum_o, m_sum);
      check("R6 address", addr_o, m_addr);
      check("R6 count", cnt_o, m_cnt);
    end
  end

  task automatic run(int a, int n, int s, bit poke_start, output int edges);
    @(negedge clk);
    start_addr = a[AW-1:0]; start_count = n[CW-1:0]; start_sum = s[15:0]; start = 1'b1;
    @(posedge clk);
    edges = 0;
    @(negedge clk);
    start = 1'b0;
    while (!done && !suspended) begin
      if (poke_start && edges == 3) begin
        start_addr = 16'd99; start_count = 16'd1; start_sum = 16'h1111; start = 1'b1;
      end else start = 1'b0;
      @(posedge clk);
      edges++;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    int e, sa, sc, ss, full;
    for (int i = 0; i < 256; i++) mem[i] = 16'((i * 40503 + 12345) ^ (i << 9));
    mem[200] = 16'hFFFF;
    repeat (3) @(negedge clk);
    check("R1 reset busy", busy, 0);
    check("R1 reset done", done, 0);
    check("R1 reset mem_req", mem_req, 0);
    check("R1 reset suspended", suspended, 0);
    rst_n = 1'b1;
    @(negedge clk);

    lat = 0;
    run(10, 8, 0, 0, e);
    check("R2 checksum n=8", sum_o, ref_sum(10, 8, 0));
    check("R9 edges L=0", e, 8 * 2 + 1);

    lat = 3;
    run(40, 5, 16'h0123, 0, e);
    check("R2 checksum with initial sum", sum_o, ref_sum(40, 5, 16'h0123));
    check("R9 edges L=3", e, 5 * 5 + 1);

    lat = 0;
    run(200, 1, 0, 0, e);
    check("R4 all-ones word normalized", sum_o, 0);

    run(0, 0, 16'h1234, 0, e);
    check("R5 zero count sum", sum_o, 16'h1234);
    check("R5 zero count edges", e, 1);
    run(0, 0, 16'hFFFF, 0, e);
    check("R5 zero count minus zero", sum_o, 0);

    lat = 1;
    run(60, 6, 0, 1, e);
    check("R8 start while busy ignored sum", sum_o, ref_sum(60, 6, 0));
    check("R8 start while busy ignored timing", e, 6 * 3 + 1);

    lat = 0;
    full = ref_sum(100, 10, 0);
    fork
      begin
        repeat (9) @(negedge clk);
        suspend_en = 1'b1; suspend_req = 1'b1;
      end
      run(100, 10, 0, 0, e);
    join
    suspend_req = 1'b0; suspend_en = 1'b0;
    check("R6 suspended seen", suspended, 1);
    sa = addr_o; sc = cnt_o; ss = sum_o;
    check("R6 words remain", (sc > 0 && sc < 10), 1);
    check("R6 address matches count", sa, 100 + 10 - sc);
    run(sa, sc, ss, 0, e);
    check("R6 resumed checksum", sum_o, full);

    suspend_req = 1'b1; suspend_en = 1'b0;
    run(120, 7, 0, 0, e);
    check("R7 disabled suspend ignored", done, 1);
    check("R7 sum", sum_o, ref_sum(120, 7, 0));
    check("R7 edges", e, 7 * 2 + 1);
    suspend_req = 1'b0;

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule